// File: doc/BRIEF.md
# I/O Line Configuration Lock

This block holds the protected configuration of a 32-line I/O controller: whether the controller or a peripheral owns each pin, multi-drive (open-drain) enables, pull-up enables, and a two-bit peripheral choice per line. Software changes these through set/clear write ports and two direct-write select registers. Beside the register file sits a per-line lock. A peripheral, such as a PWM unit that must not lose its pins, can raise the lock request for a line. From then on every write that touches that line's bit in the protected ports is dropped, while the other bits of the same write still take effect.

A lock is sticky. One cycle of request is enough, and only a hardware reset clears it. A read-only status word shows which lines are locked. The configuration is also presented on output ports for the pad logic.

Top module: `iocfg_lock`

## Requirements
- R1: On reset, all 32 lines are owned by the controller (`pioOwn` all ones), multi-drive is off, pull-ups are on, both select words are zero and no line is locked.
- R2: A `lockReq` bit that is high at a rising clock edge sets that line's lock bit at that edge. A single-cycle pulse is enough, and the bit stays set after the request drops.
- R3: On unlocked lines, a 1 written to address 0 sets ownership and a 1 written to address 1 clears it. Addresses 3 and 4 set and clear multi-drive. Address 7 sets pull-up and address 6 clears it. Zero bits in these writes change nothing.
- R4: On unlocked lines, a write to address 9 (select low) or address 10 (select high) replaces the stored bit with the written bit.
- R5: For a locked line, writes to addresses 0, 1, 3, 4, 6, 7, 9 and 10 leave that line's bit unchanged, while unlocked bits in the same write update normally.
- R6: When a lock request and a protected write hit the same line at the same edge, the lock wins and the write to that bit is discarded.
- R7: Reads are combinational on `rdAddr`. Address 11 returns the lock bits. Addresses 2, 5 and 8 return ownership, multi-drive and pull-up. Addresses 9 and 10 return the select words.
- R8: Writes to the status addresses (2, 5, 8, 11) or to unmapped addresses change no state. No write ever clears a lock bit. Only reset does.
- R9: A read from an unmapped address (12 to 15) returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 4 | Write word address |
| wrData | input | 32 | Write data, one bit per line |
| rdAddr | input | 4 | Read word address |
| rdData | output | 32 | Combinational read data |
| lockReq | input | 32 | Per-line lock requests from peripherals |
| pioOwn | output | 32 | 1 = line driven by the controller, 0 = by a peripheral |
| mdEn | output | 32 | Multi-drive enables |
| puEn | output | 32 | Pull-up enables |
| selLo | output | 32 | Peripheral select, low bit |
| selHi | output | 32 | Peripheral select, high bit |
| lockState | output | 32 | Current lock bits |

## Verification
The assertions assume that `wrAddr` and `wrData` are meaningful only while `wrEn` is high. They also assume that `lockReq` may pulse at any edge, including an edge that carries a write. A cycle without a write strobe is expected to leave the configuration untouched.

The stimulus drives every input on the falling edge and keeps `wrEn` low between operations. It pulses lock requests both alone and together with writes that hit the same bits. It mixes directed patterns with pseudo-random protected writes so that locked and unlocked bits meet in single words.

// File: rtl/iocfg_lock_pkg.sv
package iocfg_lock_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN_SET  = 4'd0,
    A_OWN_CLR  = 4'd1,
    A_OWN_STAT = 4'd2,
    A_MD_SET   = 4'd3,
    A_MD_CLR   = 4'd4,
    A_MD_STAT  = 4'd5,
    A_PU_CLR   = 4'd6,
    A_PU_SET   = 4'd7,
    A_PU_STAT  = 4'd8,
    A_SEL_LO   = 4'd9,
    A_SEL_HI   = 4'd10,
    A_LOCK     = 4'd11
  } regAddr_e;

  typedef struct packed {
    logic ownSet;
    logic ownClr;
    logic mdSet;
    logic mdClr;
    logic puSet;
    logic puClr;
    logic selLoWr;
    logic selHiWr;
  } cfgStrobe_t;
endpackage

// File: rtl/iocfg_lock_ctrl.sv
module iocfg_lock_ctrl
  import iocfg_lock_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output cfgStrobe_t        strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr_e'(wrAddr))
        A_OWN_SET: strb.ownSet  = 1'b1;
        A_OWN_CLR: strb.ownClr  = 1'b1;
        A_MD_SET:  strb.mdSet   = 1'b1;
        A_MD_CLR:  strb.mdClr   = 1'b1;
        A_PU_SET:  strb.puSet   = 1'b1;
        A_PU_CLR:  strb.puClr   = 1'b1;
        A_SEL_LO:  strb.selLoWr = 1'b1;
        A_SEL_HI:  strb.selHiWr = 1'b1;
        default:   strb = '0;  // status and unmapped writes: R8
      endcase
    end
  end
endmodule

// File: rtl/iocfg_lock_dp.sv
module iocfg_lock_dp
  import iocfg_lock_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] lockReq,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_LINES-1:0] pioOwn,
  output logic [NUM_LINES-1:0] mdEn,
  output logic [NUM_LINES-1:0] puEn,
  output logic [NUM_LINES-1:0] selLo,
  output logic [NUM_LINES-1:0] selHi,
  output logic [NUM_LINES-1:0] lockState
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic lk, own, md, pu, s0, s1;
    logic guard;

    // lock request in the same cycle already blocks the write (R6)
    assign guard = lk | lockReq[i];

    always_ff @(posedge clk) begin
      if (!rstN)           lk <= 1'b0;
      else if (lockReq[i]) lk <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        own <= 1'b1;
        md  <= 1'b0;
        pu  <= 1'b1;
        s0  <= 1'b0;
        s1  <= 1'b0;
      end else if (!guard) begin
        if (wrData[i]) begin
          if (strb.ownSet)      own <= 1'b1;
          else if (strb.ownClr) own <= 1'b0;
          if (strb.mdSet)       md  <= 1'b1;
          else if (strb.mdClr)  md  <= 1'b0;
          if (strb.puSet)       pu  <= 1'b1;
          else if (strb.puClr)  pu  <= 1'b0;
        end
        if (strb.selLoWr) s0 <= wrData[i];
        if (strb.selHiWr) s1 <= wrData[i];
      end
    end

    assign lockState[i] = lk;
    assign pioOwn[i]    = own;
    assign mdEn[i]      = md;
    assign puEn[i]      = pu;
    assign selLo[i]     = s0;
    assign selHi[i]     = s1;
  end

  always_comb begin
    case (regAddr_e'(rdAddr))
      A_OWN_STAT: rdData = pioOwn;
      A_MD_STAT:  rdData = mdEn;
      A_PU_STAT:  rdData = puEn;
      A_SEL_LO:   rdData = selLo;
      A_SEL_HI:   rdData = selHi;
      A_LOCK:     rdData = lockState;
      default:    rdData = '0;  // R9
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((lockState & $past(lockState)) == $past(lockState))); // R8
  AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq != '0) |=> ((lockState & $past(lockReq)) == $past(lockReq))); // R2
  AST_OWN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((pioOwn ^ $past(pioOwn)) & $past(lockState | lockReq)) == '0)); // R5
  AST_MD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((mdEn ^ $past(mdEn)) & $past(lockState | lockReq)) == '0)); // R5
  AST_PU_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((puEn ^ $past(puEn)) & $past(lockState | lockReq)) == '0)); // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((((selLo ^ $past(selLo)) | (selHi ^ $past(selHi)))
               & $past(lockState | lockReq)) == '0)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(pioOwn) && $stable(mdEn) && $stable(puEn)
                      && $stable(selLo) && $stable(selHi))); // R8
endmodule

// File: rtl/iocfg_lock.sv
module iocfg_lock
  import iocfg_lock_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] lockReq,
  output logic [NUM_LINES-1:0] pioOwn,
  output logic [NUM_LINES-1:0] mdEn,
  output logic [NUM_LINES-1:0] puEn,
  output logic [NUM_LINES-1:0] selLo,
  output logic [NUM_LINES-1:0] selHi,
  output logic [NUM_LINES-1:0] lockState
);
  cfgStrobe_t strb;

  iocfg_lock_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strb   (strb)
  );

  iocfg_lock_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .lockReq   (lockReq),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .pioOwn    (pioOwn),
    .mdEn      (mdEn),
    .puEn      (puEn),
    .selLo     (selLo),
    .selHi     (selHi),
    .lockState (lockState)
  );
endmodule

// File: tb/iocfg_lock_bench.sv
module iocfg_lock_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] lockReq = '0;
  logic [31:0] rdData, pioOwn, mdEn, puEn, selLo, selHi, lockState;

  iocfg_lock u_iocfg_lock (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lockReq(lockReq), .pioOwn(pioOwn),
    .mdEn(mdEn), .puEn(puEn), .selLo(selLo), .selHi(selHi), .lockState(lockState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    logic [3:0]  addr;
    logic [31:0] exp;
  } rdItem_t;

  rdItem_t     expQ[$];
  logic        sampleReq = 1'b0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  // reference model
  logic [31:0] mOwn, mMd, mPu, mS0, mS1, mLock;

  task automatic modelReset();
    mOwn = '1; mMd = '0; mPu = '1; mS0 = '0; mS1 = '0; mLock = '0;
  endtask

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'd2:    return mOwn;
      4'd5:    return mMd;
      4'd8:    return mPu;
      4'd9:    return mS0;
      4'd10:   return mS1;
      4'd11:   return mLock;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] a, logic [31:0] d, logic [31:0] lk);
    logic [31:0] open;
    @(negedge clk);
    sampleReq = 1'b0;
    wrEn = 1'b1; wrAddr = a; wrData = d; lockReq = lk;
    mLock = mLock | lk;
    open  = d & ~mLock;
    case (a)
      4'd0:  mOwn = mOwn | open;
      4'd1:  mOwn = mOwn & ~open;
      4'd3:  mMd  = mMd | open;
      4'd4:  mMd  = mMd & ~open;
      4'd6:  mPu  = mPu & ~open;
      4'd7:  mPu  = mPu | open;
      4'd9:  mS0  = (mS0 & mLock) | (d & ~mLock);
      4'd10: mS1  = (mS1 & mLock) | (d & ~mLock);
      default: ;
    endcase
  endtask

  task automatic expectRd(logic [3:0] a, string req);
    rdItem_t it;
    @(negedge clk);
    wrEn = 1'b0; lockReq = '0; rdAddr = a;
    it.req = req; it.addr = a; it.exp = modelRead(a);
    expQ.push_back(it);
    sampleReq = 1'b1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sampleReq = 1'b0; wrEn = 1'b0; lockReq = '0;
    end
  endtask

  task automatic readAll(string req);
    expectRd(4'd2, req); expectRd(4'd5, req); expectRd(4'd8, req);
    expectRd(4'd9, req); expectRd(4'd10, req); expectRd(4'd11, req);
  endtask

  // monitor: compares read data against the queued expectations
  always @(posedge clk) begin
    if (sampleReq) begin
      rdItem_t it;
      #(CLK_PERIOD/4);
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL monitor queue empty actual=%h expected=none", rdData);
      end else begin
        it = expQ.pop_front();
        chk($sformatf("%s addr=%0d", it.req, it.addr), rdData, it.exp);
      end
    end
  end

  task automatic applyReset();
    @(negedge clk);
    sampleReq = 1'b0; wrEn = 1'b0; lockReq = '0;
    rstN = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] lfsr;
    applyReset();
    // R1 reset state at the ports
    chk("R1 pioOwn", pioOwn, 32'hFFFF_FFFF);
    chk("R1 mdEn", mdEn, 32'h0);
    chk("R1 puEn", puEn, 32'hFFFF_FFFF);
    chk("R1 selLo", selLo, 32'h0);
    chk("R1 selHi", selHi, 32'h0);
    chk("R1 lockState", lockState, 32'h0);
    readAll("R1 reset read");

    // R3 set/clear ports on unlocked lines
    doWrite(4'd1, 32'h0000_00F0, '0); expectRd(4'd2, "R3 own clear");
    doWrite(4'd0, 32'h0000_0030, '0); expectRd(4'd2, "R3 own set");
    doWrite(4'd3, 32'h0000_A5A5, '0); expectRd(4'd5, "R3 md set");
    doWrite(4'd4, 32'h0000_0005, '0); expectRd(4'd5, "R3 md clear");
    doWrite(4'd6, 32'h0000_FF00, '0); expectRd(4'd8, "R3 pu clear");
    doWrite(4'd7, 32'h0000_0F00, '0); expectRd(4'd8, "R3 pu set");

    // R4 select words
    doWrite(4'd9, 32'h1234_5678, '0);  expectRd(4'd9, "R4 selLo");
    doWrite(4'd10, 32'hDEAD_BEEF, '0); expectRd(4'd10, "R4 selHi");

    // R2 single-cycle lock pulse, sticky afterwards
    doWrite(4'd15, 32'hFFFF_FFFF, 32'h0000_0018);
    expectRd(4'd11, "R2 lock set");
    idle(4);
    expectRd(4'd11, "R2 lock sticky");
    idle(1);
    chk("R7 lockState port", lockState, 32'h0000_0018);
    expectRd(4'd2, "R8 unmapped write no effect");

    // R5 masking on locked lines, partial update on others
    doWrite(4'd1, 32'hFFFF_FFFF, '0); expectRd(4'd2, "R5 own clear masked");
    doWrite(4'd0, 32'hFFFF_FFFF, '0); expectRd(4'd2, "R5 own set");
    doWrite(4'd3, 32'hFFFF_FFFF, '0); expectRd(4'd5, "R5 md set masked");
    doWrite(4'd4, 32'hFFFF_FFFF, '0); expectRd(4'd5, "R5 md clear masked");
    doWrite(4'd6, 32'hFFFF_FFFF, '0); expectRd(4'd8, "R5 pu clear masked");
    doWrite(4'd9, 32'h0000_0000, '0); expectRd(4'd9, "R5 selLo masked");
    doWrite(4'd10, 32'hFFFF_FFFF, '0); expectRd(4'd10, "R5 selHi masked");

    // R6 lock and write in the same cycle
    doWrite(4'd1, 32'h0000_0300, 32'h0000_0100);
    expectRd(4'd2, "R6 same-cycle lock wins");
    expectRd(4'd11, "R6 lock recorded");
    doWrite(4'd10, 32'h0001_0000, 32'h0001_0000);
    expectRd(4'd10, "R6 select same-cycle");

    // R8 writes to status addresses change nothing
    doWrite(4'd11, 32'h0000_0000, '0); expectRd(4'd11, "R8 lock not cleared");
    doWrite(4'd2, 32'h0000_0000, '0);  expectRd(4'd2, "R8 status write ignored");
    doWrite(4'd8, 32'hFFFF_FFFF, '0);  expectRd(4'd8, "R8 pu status write ignored");

    // R9 unmapped reads
    expectRd(4'd12, "R9 unmapped read");
    expectRd(4'd15, "R9 unmapped read");

    // R5 R2 mixed pseudo-random traffic
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 40; n++) begin
      logic [3:0] a;
      logic [31:0] lk;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0: a = 4'd0;  3'd1: a = 4'd1;  3'd2: a = 4'd3;  3'd3: a = 4'd4;
        3'd4: a = 4'd6;  3'd5: a = 4'd7;  3'd6: a = 4'd9;  default: a = 4'd10;
      endcase
      lk = (lfsr[5:3] == 3'd0) ? (32'h1 << lfsr[12:8]) : 32'h0;
      doWrite(a, {lfsr[15:0], lfsr[31:16]}, lk);
      if (n % 8 == 7) readAll("R5 random mix");
    end
    readAll("R5 random final");

    // R1 R8 only reset clears the locks
    idle(1);
    applyReset();
    chk("R8 reset clears lock", lockState, 32'h0);
    readAll("R1 second reset");
    idle(2);

    wait (expQ.size() == 0);
    idle(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule